// File: doc/BRIEF.md
# Vectored Two-Source Interrupt Controller

This unit sits beside a small microcontroller core and handles two interrupt sources: a pin that raises a request on every level change, and a single-cycle underflow pulse from a timer. Each source owns a sticky request flag. A flag is set whenever its source fires, whatever the enable state. A 2-bit control register holds one enable bit per source. A global enable flag is raised and lowered by commands from the core.

A source with its enable bit set takes part in vectored interrupts. When its flag is up and the global flag is up, the unit issues a one-cycle accept pulse, a one-hot winner and a fixed vector address. A source with its enable bit clear is instead polled by the core through a test-and-skip request. A request that finds the flag up reports a skip and clears that flag. The core does the instruction decode and the return-address stacking. The timer itself is outside the unit.

Top module: `irq_vec_unit`

## Requirements
- R1: After reset both request flags, both enable bits and the global enable flag are 0, and no accept is signalled.
- R2: `take_o` is 1 in a cycle exactly when the global enable flag is 1 and some source has both its request flag and its enable bit at 1.
- R3: A global-on command sets the global enable flag at the next edge and a global-off command clears it. When both arrive together, off wins.
- R4: An accept clears the global enable flag at the next edge. This holds even when a global-on command arrives in the same cycle.
- R5: A request flag, once set, stays set until it is accepted or cleared by a skip. Enable bits and the global flag do not affect the setting.
- R6: Any change of level on `ext_pin_i`, rising or falling, sets request flag 0. The flag is visible after the third rising clock edge that follows the change, because of the two synchronizer stages and the edge detector.
- R7: A 1 on `tmr_uflow_i` sets request flag 1 at the next edge.
- R8: The external source (bit 0) beats the timer (bit 1). `take_src_o` is one-hot for the winner. `take_vec_o` is page 1 with offset 0 (13'h080) for the external source and offset 2 (13'h082) for the timer. Only the winner's flag is cleared.
- R9: `poll_skip_o` is `poll_req_i` AND the flag selected by `poll_sel_i` (0 = external, 1 = timer) AND NOT that source's enable bit. A skip clears the selected flag at the next edge. With the enable bit at 1, the poll has no effect on the flag.
- R10: When a source fires in the same cycle that its flag is being cleared, the flag is 1 after the edge.
- R11: A write with `ctl_we_i` loads `ctl_wdata_i` into the enable bits at the next edge.
- R12: A flag that stays pending while interrupts are off is accepted in the first cycle after the global flag is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| tmr_uflow_i | input | 1 | Timer underflow pulse |
| gie_on_i | input | 1 | Global enable command |
| gie_off_i | input | 1 | Global disable command |
| ctl_we_i | input | 1 | Enable-bit register write strobe |
| ctl_wdata_i | input | 2 | New enable bits (bit 0 external, bit 1 timer) |
| poll_req_i | input | 1 | Test-and-skip request |
| poll_sel_i | input | 1 | Source selected by the poll |
| take_o | output | 1 | Interrupt accepted this cycle |
| take_src_o | output | 2 | One-hot accepted source |
| take_vec_o | output | 13 | Vector address of accepted source |
| poll_skip_o | output | 1 | Poll result: skip the next instruction |
| gie_o | output | 1 | Global enable flag |
| req_flags_o | output | 2 | Request flags |
| ctl_en_o | output | 2 | Enable bits |

## Verification
Accepting one source and poll-clearing the other can fall in the same cycle. The bench provokes this by enabling only the timer, letting both flags rise, and then issuing an external poll in the cycle where the timer is accepted. It then expects both flags to be 0 after that edge. Source setting and flag clearing also coincide: a timer pulse is driven in the very cycle the timer interrupt is accepted, and the flag must remain set.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC      = 2;
  localparam int SEL_W     = $clog2(NSRC);
  localparam int SRC_EXT   = 0;
  localparam int SRC_TMR   = 1;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic toggle_o
);
  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
  logic [STAGES:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign toggle_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar g = 0; g < N; g++) begin : g_flag
    // a fresh set overrides a clear in the same cycle
    always_comb flag_d[g] = set_i[g] | (flag_q[g] & ~clr_i[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= flag_d[g];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N        = 2,
  parameter int PAGE_W   = 6,
  parameter int OFS_W    = 7,
  parameter int VEC_PAGE = 1,
  parameter int STRIDE   = 2,
  localparam int ADDR_W  = PAGE_W + OFS_W
) (
  input  logic              gie_i,
  input  logic [N-1:0]      flag_i,
  input  logic [N-1:0]      en_i,
  output logic              take_o,
  output logic [N-1:0]      win_o,
  output logic [ADDR_W-1:0] vec_o
);
  logic [N-1:0]     cand;
  logic [N-1:0]     pick;
  logic             found;
  logic [OFS_W-1:0] ofs;

  always_comb begin
    cand  = flag_i & en_i;
    pick  = '0;
    found = 1'b0;
    ofs   = '0;
    // lowest index has the highest priority
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
        ofs     = OFS_W'(i * STRIDE);
      end
    end
  end

  assign take_o = gie_i & found;
  assign win_o  = gie_i ? pick : '0;
  assign vec_o  = {PAGE_W'(VEC_PAGE), ofs};
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_W      = 6,
  parameter int OFS_W       = 7,
  parameter int VEC_PAGE    = 1,
  parameter int VEC_STRIDE  = 2,
  localparam int ADDR_W     = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin_i,
  input  logic              tmr_uflow_i,
  input  logic              gie_on_i,
  input  logic              gie_off_i,
  input  logic              ctl_we_i,
  input  logic [NSRC-1:0]   ctl_wdata_i,
  input  logic              poll_req_i,
  input  logic [SEL_W-1:0]  poll_sel_i,
  output logic              take_o,
  output logic [NSRC-1:0]   take_src_o,
  output logic [ADDR_W-1:0] take_vec_o,
  output logic              poll_skip_o,
  output logic              gie_o,
  output logic [NSRC-1:0]   req_flags_o,
  output logic [NSRC-1:0]   ctl_en_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q = rst_pipe_q[1];

  logic            ext_toggle;
  logic [NSRC-1:0] src_set, src_clr, poll_clr, win, flags;
  logic [NSRC-1:0] en_q, en_d;
  logic            gie_q, gie_d;
  logic            take, skip;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_q),
    .pin_i    (ext_pin_i),
    .toggle_o (ext_toggle)
  );

  always_comb begin
    src_set          = '0;
    src_set[SRC_EXT] = ext_toggle;
    src_set[SRC_TMR] = tmr_uflow_i;
  end

  irq_flag_bank #(.N(NSRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_q),
    .set_i  (src_set),
    .clr_i  (src_clr),
    .flag_o (flags)
  );

  irq_arb #(
    .N(NSRC), .PAGE_W(PAGE_W), .OFS_W(OFS_W),
    .VEC_PAGE(VEC_PAGE), .STRIDE(VEC_STRIDE)
  ) u_arb (
    .gie_i  (gie_q),
    .flag_i (flags),
    .en_i   (en_q),
    .take_o (take),
    .win_o  (win),
    .vec_o  (take_vec_o)
  );

  // polled test-and-skip: only for sources whose enable bit is clear
  always_comb begin
    skip     = poll_req_i & flags[poll_sel_i] & ~en_q[poll_sel_i];
    poll_clr = '0;
    if (skip) poll_clr[poll_sel_i] = 1'b1;
    src_clr  = win | poll_clr;
  end

  // next state for global flag and enable register
  always_comb begin
    if (take)           gie_d = 1'b0;
    else if (gie_off_i) gie_d = 1'b0;
    else if (gie_on_i)  gie_d = 1'b1;
    else                gie_d = gie_q;
    en_d = ctl_we_i ? ctl_wdata_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      gie_q <= 1'b0;
      en_q  <= '0;
    end else begin
      gie_q <= gie_d;
      en_q  <= en_d;
    end
  end

  assign take_o      = take;
  assign take_src_o  = win;
  assign poll_skip_o = skip;
  assign gie_o       = gie_q;
  assign req_flags_o = flags;
  assign ctl_en_o    = en_q;
endmodule

// File: rtl/irq_vec_unit_chk.sv
module irq_vec_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tmr_uflow_i,
  input logic       gie_on_i,
  input logic       gie_off_i,
  input logic       poll_sel_i,
  input logic       take_o,
  input logic [1:0] take_src_o,
  input logic       poll_skip_o,
  input logic       gie_o,
  input logic [1:0] req_flags_o,
  input logic [1:0] ctl_en_o
);
  AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (gie_o && (|(req_flags_o & ctl_en_o)))); // R2
  AST_GIE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_on_i && !gie_off_i && !take_o) |=> gie_o); // R3
  AST_GIE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !gie_o); // R4
  AST_TMR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_flags_o[1] && !take_src_o[1] && !(poll_skip_o && poll_sel_i)) |=> req_flags_o[1]); // R5
  AST_TMR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_uflow_i |=> req_flags_o[1]); // R7
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($countones(take_src_o) == 1)); // R8
  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && req_flags_o[0] && ctl_en_o[0]) |-> take_src_o[0]); // R8
  AST_POLL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    poll_skip_o |-> !ctl_en_o[poll_sel_i]); // R9
  AST_POLL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_skip_o && poll_sel_i && !tmr_uflow_i) |=> !req_flags_o[1]); // R9
endmodule

bind irq_vec_unit irq_vec_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .tmr_uflow_i (tmr_uflow_i),
  .gie_on_i    (gie_on_i),
  .gie_off_i   (gie_off_i),
  .poll_sel_i  (poll_sel_i),
  .take_o      (take_o),
  .take_src_o  (take_src_o),
  .poll_skip_o (poll_skip_o),
  .gie_o       (gie_o),
  .req_flags_o (req_flags_o),
  .ctl_en_o    (ctl_en_o)
);

// File: tb/sim_irq_vec_unit.sv
module sim_irq_vec_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_pin, tmr_uflow, gie_on, gie_off, ctl_we, poll_req, poll_sel;
  logic [1:0]  ctl_wdata;
  logic        take, poll_skip, gie;
  logic [1:0]  take_src, flags, ctl_en;
  logic [12:0] take_vec;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_vec_unit u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .tmr_uflow_i(tmr_uflow),
    .gie_on_i(gie_on), .gie_off_i(gie_off), .ctl_we_i(ctl_we),
    .ctl_wdata_i(ctl_wdata), .poll_req_i(poll_req), .poll_sel_i(poll_sel),
    .take_o(take), .take_src_o(take_src), .take_vec_o(take_vec),
    .poll_skip_o(poll_skip), .gie_o(gie), .req_flags_o(flags), .ctl_en_o(ctl_en)
  );

  // [14]tmr [13]on [12]off [11]we [10:9]wdata [8]poll [7]sel |
  // [6]take [5:4]src [3]skip (this cycle) | [2:1]flags [0]gie (after edge)
  localparam int NROW = 13;
  localparam logic [14:0] TBL [NROW] = '{
    15'b1_0_0_0_00_0_0_0_00_0_10_0,
    15'b0_0_0_0_00_1_1_0_00_1_00_0,
    15'b0_0_0_0_00_1_1_0_00_0_00_0,
    15'b1_0_0_1_10_0_0_0_00_0_10_0,
    15'b0_0_0_0_00_1_1_0_00_0_10_0,
    15'b0_1_0_0_00_0_0_0_00_0_10_1,
    15'b0_0_0_0_00_0_0_1_10_0_00_0,
    15'b0_0_0_0_00_0_0_0_00_0_00_0,
    15'b1_1_0_0_00_0_0_0_00_0_10_1,
    15'b1_0_1_0_00_0_0_1_10_0_10_0,
    15'b0_1_1_0_00_0_0_0_00_0_10_0,
    15'b0_1_0_0_00_0_0_0_00_0_10_1,
    15'b0_1_0_0_00_0_0_1_10_0_00_0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    tmr_uflow = 0; gie_on = 0; gie_off = 0; ctl_we = 0; ctl_wdata = 0;
    poll_req = 0; poll_sel = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; ext_pin = 0; idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) tick();
    check("R1 flags", flags, 0);
    check("R1 en", ctl_en, 0);
    check("R1 gie", gie, 0);
    check("R1 take", take, 0);

    for (int r = 0; r < NROW; r++) begin
      tmr_uflow = TBL[r][14]; gie_on = TBL[r][13]; gie_off = TBL[r][12];
      ctl_we = TBL[r][11]; ctl_wdata = TBL[r][10:9];
      poll_req = TBL[r][8]; poll_sel = TBL[r][7];
      #1;
      check("R2 take", take, TBL[r][6]);
      check("R8 src", take_src, TBL[r][5:4]);
      if (TBL[r][6]) check("R8 vec", take_vec, TBL[r][5] ? 13'h082 : 13'h080);
      check("R9 skip", poll_skip, TBL[r][3]);
      tick();
      check("R5 R7 R10 flags", flags, TBL[r][2:1]);
      check("R3 R4 R12 gie", gie, TBL[r][0]);
    end
    idle();
    check("R11 en", ctl_en, 2'b10);

    // R6: both edges of the pin, three-edge latency
    ext_pin = 1;
    tick(); check("R6 edge1", flags[0], 0);
    tick(); check("R6 edge2", flags[0], 0);
    tick(); check("R6 rise", flags[0], 1);
    poll_req = 1; poll_sel = 0; #1;
    check("R9 ext skip", poll_skip, 1);
    tick(); idle();
    check("R9 ext cleared", flags[0], 0);
    ext_pin = 0;
    tick(); tick(); tick();
    check("R6 fall", flags[0], 1);
    poll_req = 1; poll_sel = 0; tick(); idle();

    // R8 / R12: both pending, priority and vectors
    ctl_we = 1; ctl_wdata = 2'b11; tmr_uflow = 1; ext_pin = 1;
    tick(); idle(); tick(); tick();
    check("R11 en both", ctl_en, 2'b11);
    check("R5 both pending", flags, 2'b11);
    gie_on = 1; tick(); idle(); #1;
    check("R12 take", take, 1);
    check("R8 ext wins", take_src, 2'b01);
    check("R8 ext vec", take_vec, 13'h080);
    tick();
    check("R8 only winner cleared", flags, 2'b10);
    check("R4 gie off", gie, 0);
    gie_on = 1; tick(); idle(); #1;
    check("R8 tmr src", take_src, 2'b10);
    check("R8 tmr vec", take_vec, 13'h082);
    tick();
    check("R8 all clear", flags, 2'b00);

    // collision: timer accept and external poll in one cycle
    ctl_we = 1; ctl_wdata = 2'b10; tmr_uflow = 1; ext_pin = 0;
    tick(); idle(); tick(); tick();
    check("R5 setup", flags, 2'b11);
    gie_on = 1; tick(); idle();
    poll_req = 1; poll_sel = 0; #1;
    check("R2 take coincident", take, 1);
    check("R8 tmr coincident", take_src, 2'b10);
    check("R9 skip coincident", poll_skip, 1);
    tick(); idle();
    check("R9 R8 both cleared", flags, 2'b00);
    check("R4 gie after", gie, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule